// File: doc/BRIEF.md
# Buffered Capture/Compare Timer Channel

This block is one channel of a general-purpose timer. A 16-bit up-counter advances on a count-enable strobe. Two main registers, A and B, each act either as a capture register, which records the counter value when an edge is seen on its own capture input, or as a compare register, which raises an event when the counter equals it. A flag per register records that an event happened. Software clears the flag by writing a 1 to it.

Each main register can be paired with a shadow register: C shadows A and D shadows B. Each pair has its own enable. The shadow works in opposite directions depending on the function. On a capture, the old main value moves into the shadow before the new count is stored. On a compare match, the shadow value is loaded into the main register. This lets software stage the next compare value at any time without glitching the current one.

A PWM mode turns both registers into compare registers. A sets the period: the counter clears to zero on the A match. B sets the duty point. On the A match, both enabled shadows load their main registers together.

Top module: `capcmp_timer`

## Requirements
- R1: After a synchronous reset, the counter, registers A, B, C and D, the control word and both flags are all zero.
- R2: While `cnt_en` is high, the counter increases by one on each clock edge. While `cnt_en` is low, it holds its value. The wrap described in R6 is the only exception.
- R3: The control word is written at address 4. Bits [2:0] select the capture edge for A and bits [5:3] select it for B. The codes are: 000 no capture, 001 rising edge, 010 both edges, 100 falling edge; any other code gives no capture. Bit 6 (for A) and bit 7 (for B) select compare when set and capture when clear. A captured edge loads the counter value into the main register on the third clock edge after the input changes.
- R4: Bit 8 enables the A/C pair and bit 9 enables the B/D pair. With the pair enabled, a capture moves the previous main value into the shadow in the same edge that the main register takes the counter value.
- R5: In compare mode, a match is `cnt_en` high while the counter equals the main register. A match sets the flag. With the pair enabled, the match also loads the shadow into the main register on that edge. With the pair disabled, the main register is left unchanged.
- R6: When control bit 10 is set (PWM mode), an A match clears the counter to zero. The same match loads C into A and D into B for each enabled pair. A B match sets the B flag only. Capture inputs are ignored in this mode.
- R7: Flag bit 0 belongs to A and flag bit 1 to B. A write to address 5 with data bit i set clears flag i. An event in the same cycle wins over the clear.
- R8: Register writes use address 0 for A, 1 for B, 2 for C and 3 for D. A write to C or D leaves the main register untouched until the next transfer.
- R9: If a capture and a software write to the same main register fall in the same cycle, the capture value is stored and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable strobe |
| cap_a_in | input | 1 | Asynchronous capture input for register A |
| cap_b_in | input | 1 | Asynchronous capture input for register B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 A, 1 B, 2 C, 3 D, 4 control, 5 flag clear) |
| wr_data | input | 16 | Write data |
| count | output | 16 | Counter value |
| reg_a | output | 16 | Main register A |
| reg_b | output | 16 | Main register B |
| reg_c | output | 16 | Shadow register C |
| reg_d | output | 16 | Shadow register D |
| evt_flag | output | 2 | Event flags: bit 0 for A, bit 1 for B |

## Verification
A capture on register A and a software write to A can land on the same clock edge. The bench provokes this by raising the capture input and then timing a write to A so that it is presented in the cycle where the synchronised edge is recognised, two edges after the input change. The result is judged by reading A afterwards. It must hold the frozen counter value, not the written data, and the A flag must be set.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [2:0] EDGE_NONE = 3'b000;
  localparam logic [2:0] EDGE_RISE = 3'b001;
  localparam logic [2:0] EDGE_BOTH = 3'b010;
  localparam logic [2:0] EDGE_FALL = 3'b100;

  localparam logic [ADDR_W-1:0] AD_MAIN0 = 3'd0;
  localparam logic [ADDR_W-1:0] AD_SHAD0 = 3'd2;
  localparam logic [ADDR_W-1:0] AD_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] AD_FCLR  = 3'd5;

  typedef struct packed {
    logic       pwm;
    logic [1:0] buf_en;
    logic [1:0] is_cmp;
    logic [2:0] sel_b;
    logic [2:0] sel_a;
  } ctrl_t;
endpackage

// File: rtl/cct_edge_det.sv
module cct_edge_det (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [2:0] sel,
  output logic       evt
);
  import cct_pkg::*;
  logic s1, s2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      prev <= s2;
    end
  end

  logic rise, fall;
  assign rise = s2 & ~prev;
  assign fall = ~s2 & prev;

  always_comb begin
    unique case (sel)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         wrap,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else if (step) value <= wrap ? '0 : value + 1'b1;
  end
endmodule

// File: rtl/cct_slot.sv
module cct_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_evt,
  input  logic         xfer_evt,
  input  logic         buf_en,
  input  logic [W-1:0] count,
  input  logic         wr_main,
  input  logic         wr_shad,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] main_q,
  output logic [W-1:0] shad_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= '0;
    end else if (cap_evt) begin
      main_q <= count;
    end else if (xfer_evt && buf_en) begin
      main_q <= shad_q;
    end else if (wr_main) begin
      main_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shad_q <= '0;
    end else if (cap_evt && buf_en) begin
      shad_q <= main_q;
    end else if (wr_shad) begin
      shad_q <= wr_data;
    end
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int W = cct_pkg::CNT_W,
  parameter int NSLOT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         cap_a_in,
  input  logic         cap_b_in,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic [W-1:0] reg_c,
  output logic [W-1:0] reg_d,
  output logic [1:0]   evt_flag
);
  import cct_pkg::*;

  ctrl_t ctrl_q;
  logic pwm;
  logic [NSLOT-1:0] buf_en, is_cmp, edge_evt, cap_evt, cmp_evt, xfer_evt, match;
  logic [NSLOT-1:0] cap_in;
  logic [NSLOT-1:0][2:0] sel;
  logic [NSLOT-1:0][W-1:0] main_q, shad_q;
  logic wrap;

  assign pwm    = ctrl_q.pwm;
  assign buf_en = ctrl_q.buf_en;
  assign is_cmp = ctrl_q.is_cmp;
  assign sel[0] = ctrl_q.sel_a;
  assign sel[1] = ctrl_q.sel_b;
  assign cap_in = {cap_b_in, cap_a_in};

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == AD_CTRL) ctrl_q <= ctrl_t'(wr_data[10:0]);
  end

  assign wrap = pwm & match[0];

  cct_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .step(cnt_en), .wrap(wrap), .value(count)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic wr_main_i, wr_shad_i;
    assign wr_main_i = wr_en && (wr_addr == AD_MAIN0 + 3'(i));
    assign wr_shad_i = wr_en && (wr_addr == AD_SHAD0 + 3'(i));
    assign match[i]  = cnt_en && (count == main_q[i]);
    assign cap_evt[i] = ~pwm & ~is_cmp[i] & edge_evt[i];
    assign cmp_evt[i] = (pwm | is_cmp[i]) & match[i];
    assign xfer_evt[i] = pwm ? match[0] : cmp_evt[i];

    cct_edge_det u_edge (
      .clk(clk), .rst(rst), .din(cap_in[i]), .sel(sel[i]), .evt(edge_evt[i])
    );

    cct_slot #(.W(W)) u_slot (
      .clk(clk), .rst(rst), .cap_evt(cap_evt[i]), .xfer_evt(xfer_evt[i]),
      .buf_en(buf_en[i]), .count(count), .wr_main(wr_main_i),
      .wr_shad(wr_shad_i), .wr_data(wr_data),
      .main_q(main_q[i]), .shad_q(shad_q[i])
    );

    always_ff @(posedge clk) begin
      if (rst) evt_flag[i] <= 1'b0;
      else if (cap_evt[i] | cmp_evt[i]) evt_flag[i] <= 1'b1;
      else if (wr_en && wr_addr == AD_FCLR && wr_data[i]) evt_flag[i] <= 1'b0;
    end
  end

  assign reg_a = main_q[0];
  assign reg_b = main_q[1];
  assign reg_c = shad_q[0];
  assign reg_d = shad_q[1];
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic         pwm,
  input logic [1:0]   buf_en,
  input logic [1:0]   cap_evt,
  input logic [1:0]   cmp_evt,
  input logic [W-1:0] count,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_c,
  input logic [1:0]   evt_flag
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    cnt_en && !(pwm && count == reg_a) |=> count == W'($past(count) + 1'b1)); // R2
  AST_PWM_WRAP: assert property (@(posedge clk) disable iff (rst)
    pwm && cnt_en && count == reg_a |=> count == '0); // R6
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    cap_evt[0] |=> reg_a == $past(count)); // R9
  AST_CAP_PUSH: assert property (@(posedge clk) disable iff (rst)
    cap_evt[0] && buf_en[0] |=> reg_c == $past(reg_a)); // R4
  AST_CMP_XFER: assert property (@(posedge clk) disable iff (rst)
    cmp_evt[0] && buf_en[0] |=> reg_a == $past(reg_c)); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (cap_evt[0] || cmp_evt[0]) |=> evt_flag[0]); // R7
  AST_FLAG_SET_B: assert property (@(posedge clk) disable iff (rst)
    (cap_evt[1] || cmp_evt[1]) |=> evt_flag[1]); // R7
endmodule

bind capcmp_timer cct_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .pwm(pwm), .buf_en(buf_en),
  .cap_evt(cap_evt), .cmp_evt(cmp_evt), .count(count), .reg_a(reg_a),
  .reg_c(reg_c), .evt_flag(evt_flag)
);

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0, cap_a_in = 1'b0, cap_b_in = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count, reg_a, reg_b, reg_c, reg_d;
  logic [1:0] evt_flag;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capcmp_timer uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cap_a_in(cap_a_in),
    .cap_b_in(cap_b_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .reg_d(reg_d), .evt_flag(evt_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    cnt_en = 1'b0; cap_a_in = 1'b0; cap_b_in = 1'b0;
    rst = 1'b1;
    tick(5);
    rst = 1'b0;
  endtask

  task automatic run_to(input int target);
    cnt_en = 1'b1;
    while (count != 16'(target)) tick();
    cnt_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 regs", int'(reg_a | reg_b | reg_c | reg_d), 0);
    chk("R1 flags", evt_flag, 0);
  endtask

  task automatic t_count();
    cnt_en = 1'b1; tick(10); cnt_en = 1'b0;
    chk("R2 count after 10", count, 10);
    tick(3);
    chk("R2 hold", count, 10);
  endtask

  task automatic t_cap_rise();
    wr(3'd4, 16'h0001);
    cap_a_in = 1'b1;
    tick(2);
    chk("R3 not yet captured", reg_a, 0);
    tick();
    chk("R3 rising capture", reg_a, 10);
    chk("R7 flag A set", evt_flag[0], 1);
    wr(3'd5, 16'h0001);
    chk("R7 flag A cleared", evt_flag[0], 0);
    run_to(25);
    cap_a_in = 1'b0; tick(5);
    chk("R3 falling ignored on 001", reg_a, 10);
    chk("R3 no flag on 001 fall", evt_flag[0], 0);
    wr(3'd4, 16'h0000);
    cap_a_in = 1'b1; tick(5); cap_a_in = 1'b0; tick(5);
    chk("R3 code 000 no capture", reg_a, 10);
    chk("R3 code 000 no flag", evt_flag[0], 0);
  endtask

  task automatic t_cap_buf();
    wr(3'd4, 16'h0104);
    cap_a_in = 1'b1; tick(5);
    chk("R3 rise ignored on 100", reg_a, 10);
    cap_a_in = 1'b0; tick(3);
    chk("R4 A takes count", reg_a, 25);
    chk("R4 C takes old A", reg_c, 10);
  endtask

  task automatic t_both_b();
    wr(3'd4, 16'h0010);
    run_to(30);
    cap_b_in = 1'b1; tick(3);
    chk("R3 both-edge rise on B", reg_b, 30);
    run_to(33);
    cap_b_in = 1'b0; tick(3);
    chk("R3 both-edge fall on B", reg_b, 33);
    chk("R7 flag B set", evt_flag[1], 1);
  endtask

  task automatic t_collision();
    wr(3'd4, 16'h0001);
    run_to(40);
    wr(3'd5, 16'h0003);
    cap_a_in = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h1234;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk("R9 capture beats write", reg_a, 40);
    chk("R9 flag A on collision", evt_flag[0], 1);
    cap_a_in = 1'b0; tick(4);
  endtask

  task automatic t_compare();
    int ca, cb;
    do_reset();
    wr(3'd0, 16'd5);
    wr(3'd1, 16'd3);
    wr(3'd4, 16'h01C0);
    wr(3'd2, 16'd9);
    chk("R8 C write leaves A", reg_a, 5);
    chk("R8 C written", reg_c, 9);
    ca = -1; cb = -1;
    cnt_en = 1'b1;
    for (int k = 0; k < 20 && ca < 0; k++) begin
      tick();
      if (evt_flag[1] && cb < 0) cb = count;
      if (evt_flag[0] && ca < 0) begin
        ca = count;
        chk("R5 A loaded from C", reg_a, 9);
      end
    end
    cnt_en = 1'b0;
    chk("R5 A match timing", ca, 6);
    chk("R5 B match timing", cb, 4);
    chk("R5 B unbuffered unchanged", reg_b, 3);
  endtask

  task automatic t_pwm();
    int seen;
    do_reset();
    wr(3'd0, 16'd3);
    wr(3'd1, 16'd1);
    wr(3'd2, 16'd7);
    wr(3'd3, 16'd2);
    wr(3'd4, 16'h0700);
    seen = 0;
    cnt_en = 1'b1;
    for (int k = 0; k < 20 && !seen; k++) begin
      tick();
      if (evt_flag[0]) seen = 1;
    end
    chk("R6 wrap to zero", count, 0);
    chk("R6 A from C", reg_a, 7);
    chk("R6 B from D", reg_b, 2);
    tick(7);
    chk("R6 reaches new period", count, 7);
    tick();
    chk("R6 wraps at new period", count, 0);
    cnt_en = 1'b0;
    wr(3'd4, 16'h0701);
    wr(3'd5, 16'h0001);
    cap_a_in = 1'b1; tick(5);
    chk("R6 capture ignored", reg_a, 7);
    chk("R6 no capture flag", evt_flag[0], 0);
    cap_a_in = 1'b0;
  endtask

  initial begin
    do_reset();
    t_reset();
    t_count();
    t_cap_rise();
    t_cap_buf();
    t_both_b();
    t_collision();
    t_compare();
    t_pwm();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule